// File: doc/BRIEF.md
# Free-Running Timer Counter with Guarded Overflow Flag

This block is a 16-bit up-counter that runs on its own and sits behind a small word-addressed register window. A 3-bit rate field divides the system clock by a power of two to form the count enable. When the count rolls over from all ones to zero, a sticky wrap flag is set. If the software-programmed priority field is non-zero, an interrupt request is raised for as long as the flag stays set.

Software clears the flag with a two-step exchange. First it reads the control word and sees the flag as one. Then it writes the control word with the flag bit at zero. An internal armed bit records the first step. A rollover that lands between the read and the write disarms it, so a flag that was set again during the exchange is never lost. Software can also load the count at any time, and counting resumes from the loaded value.

The window holds four 16-bit words at byte offsets 0, 2, 4 and 6. Accesses use a single-cycle strobe. Read data is registered and appears one clock after the strobe.

Top module: `frc_timer`

## Requirements
- R1: While and after synchronous reset the flag, the priority, drive, arbitration and rate fields and the count are zero, `irq_req` is low, and the first read of offset 2 after reset returns 0x0000.
- R2: With rate code `s` in control bits 2:0, the count advances by one every 2^s clocks (code 0 counts every clock), and never changes by any other amount unless software loads it.
- R3: A rollover of the count from 0xFFFF to 0x0000 sets the flag, which is control bit 15, on the same clock edge.
- R4: `irq_req` is high exactly when the flag is set and the priority field, control bits 14:12, is non-zero. It changes on the same edge as the flag or the field.
- R5: A read of offset 0 that returns the flag as one, followed by a write to offset 0 with bit 15 at zero, clears the flag.
- R6: A write of zero to bit 15 that was not preceded by a read returning the flag as one leaves the flag set.
- R7: If a rollover occurs after the arming read and before the clearing write, that write leaves the flag set.
- R8: Writing one to bit 15 never sets the flag. Only a rollover sets it.
- R9: Offsets 4 and 6 and any odd byte address read as zero, and writes to them change nothing. Control bits 7:3 read as zero. Control bits 11 (arbitration), 10:9 (drive) and 2:0 (rate) read back as written.
- R10: A write to offset 2 loads the count with the written value, and counting continues upward from it.
- R11: `bus_rdata` shows the addressed word on the clock after a read strobe. It is zero after any cycle without a read.
- R12: Control bit 8 reads the level of `pin_in` after one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | External level shown in control bit 8 |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following. A rollover sets the flag and disarms the clear. The flag only rises after a rollover and only falls when the armed bit was set. The interrupt output follows the flag and the priority field. The count only holds or steps by one when no load is in progress. Reserved and odd addresses read back zero. The scenarios are the only way to show the rest: the exact division ratio of each rate code, that a load is followed by counting from the loaded value, and the full read-then-write exchange. They also cover its cancellation by a rollover in the middle and the effect of a write that was never armed.

// File: rtl/frc_pkg.sv
package frc_pkg;
  // control word field positions (software decodes these)
  localparam int FLAG_BIT = 15;
  localparam int LVL_LSB  = 12;
  localparam int LVL_W    = 3;
  localparam int ARB_BIT  = 11;
  localparam int DRV_LSB  = 9;
  localparam int DRV_W    = 2;
  localparam int PIN_BIT  = 8;
  localparam int SEL_LSB  = 0;

  // word slots inside the register window
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_CNT  = 1;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             arb;
    logic [DRV_W-1:0] drv;
  } ctrl_fields_t;
endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int PRE_W = NTAP - 1;

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  taps;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 2^k clocks
  assign taps[0] = 1'b1;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = &pre_q[k-1:0];
  end

  assign tick = taps[sel];
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  // a load takes priority over an increment in the same cycle
  assign wrap = tick && !ld && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frc_regs.sv
module frc_regs
  import frc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic              wrap,
  output logic [SEL_W-1:0]  sel_q,
  output logic              ld_cnt,
  output logic              flag_q,
  output logic              armed_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              irq_q,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int WORD_W = ADDR_W - 1;

  logic [WORD_W-1:0] word;
  logic              even, rd_ok, wr_ok, hit_ctrl, hit_cnt;
  ctrl_fields_t      fld_q, fld_d;
  logic [SEL_W-1:0]  sel_d;
  logic              flag_d, armed_d, pin_q;
  logic [DATA_W-1:0] rdata_d, ctrl_word;

  assign word     = bus_addr[ADDR_W-1:1];
  assign even     = !bus_addr[0];
  assign rd_ok    = bus_en && !bus_we && even;
  assign wr_ok    = bus_en &&  bus_we && even;
  assign hit_ctrl = (word == WORD_W'(SLOT_CTRL));
  assign hit_cnt  = (word == WORD_W'(SLOT_CNT));
  assign ld_cnt   = wr_ok && hit_cnt;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[FLAG_BIT]                = flag_q;
    ctrl_word[LVL_LSB +: LVL_W]        = fld_q.lvl;
    ctrl_word[ARB_BIT]                 = fld_q.arb;
    ctrl_word[DRV_LSB +: DRV_W]        = fld_q.drv;
    ctrl_word[PIN_BIT]                 = pin_q;
    ctrl_word[SEL_LSB +: SEL_W]        = sel_q;
  end

  always_comb begin
    fld_d   = fld_q;
    sel_d   = sel_q;
    flag_d  = flag_q;
    armed_d = armed_q;
    if (wr_ok && hit_ctrl) begin
      fld_d.lvl = bus_wdata[LVL_LSB +: LVL_W];
      fld_d.arb = bus_wdata[ARB_BIT];
      fld_d.drv = bus_wdata[DRV_LSB +: DRV_W];
      sel_d     = bus_wdata[SEL_LSB +: SEL_W];
      if (!bus_wdata[FLAG_BIT]) begin
        if (armed_q) flag_d = 1'b0;
        armed_d = 1'b0;
      end
    end
    if (rd_ok && hit_ctrl) armed_d = flag_q;
    // a rollover wins over any clear and cancels the pending one
    if (wrap) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      if (hit_ctrl)     rdata_d = ctrl_word;
      else if (hit_cnt) rdata_d = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q   <= '0;
      sel_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      pin_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      fld_q   <= fld_d;
      sel_q   <= sel_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
      pin_q   <= pin_in;
      irq_q   <= flag_d && (fld_d.lvl != '0);
      rdata_q <= rdata_d;
    end
  end

  assign lvl_q = fld_q.lvl;
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);
  logic [SEL_W-1:0]  sel_q;
  logic              tick, ld_cnt, wrap, flag_q, armed_q;
  logic [DATA_W-1:0] cnt_q;
  logic [LVL_W-1:0]  lvl_q;

  frc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .sel(sel_q), .tick(tick)
  );

  frc_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .ld(ld_cnt),
    .ld_val(bus_wdata), .cnt_q(cnt_q), .wrap(wrap)
  );

  frc_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_q), .wrap(wrap),
    .sel_q(sel_q), .ld_cnt(ld_cnt), .flag_q(flag_q), .armed_q(armed_q),
    .lvl_q(lvl_q), .irq_q(irq_req), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_req,
  input logic              flag_q,
  input logic              armed_q,
  input logic [LVL_W-1:0]  lvl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              wrap,
  input logic              ld_cnt
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_req && !flag_q && cnt_q == '0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !ld_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst) wrap |=> flag_q); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq_req == (flag_q && lvl_q != '0)); // R4
  AST_CLEAR_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(armed_q)); // R5
  AST_WRAP_DISARMS: assert property (@(posedge clk) disable iff (rst) wrap |=> !armed_q); // R7
  AST_ONLY_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(wrap)); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && (bus_addr[0] || bus_addr[ADDR_W-1:1] > 1))
      |=> bus_rdata == '0); // R9
endmodule

bind frc_timer frc_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(frc_pkg::LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_req(irq_req), .flag_q(flag_q), .armed_q(armed_q),
  .lvl_q(lvl_q), .cnt_q(cnt_q), .wrap(wrap), .ld_cnt(ld_cnt)
);

// File: tb/frc_timer_tb.sv
module frc_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_rd = '0;
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  frc_timer u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // empty tag: value captured in last_rd, not compared
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= bus_en && !bus_we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      last_rd = bus_rdata;
      if (t != "") check(bus_rdata === e, t, bus_rdata, e);
    end
  end

  // count delta over an exact window of clocks
  task automatic measure(input int cycles, input logic [15:0] steps, input string tag);
    logic [15:0] a, b;
    rd(3'd2, 16'h0, "");
    #1 a = last_rd;
    repeat (cycles - 1) @(negedge clk);
    rd(3'd2, 16'h0, "");
    #1 b = last_rd;
    check((b - a) == steps, tag, b - a, steps);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(irq_req === 1'b0, "R1 irq after reset", 16'(irq_req), 16'h0);
    rd(3'd2, 16'h0000, "R1 count after reset");
    rd(3'd0, 16'h0000, "R1 control after reset");

    // R10 load then keep counting
    wr(3'd2, 16'h1234);
    rd(3'd2, 16'h1234, "R10 loaded value");
    rd(3'd2, 16'h1235, "R10 counts on from load");
    @(negedge clk);
    check(bus_rdata === 16'h0, "R11 idle read data", bus_rdata, 16'h0);

    // R2 rate codes
    wr(3'd0, 16'h0003);
    measure(64, 16'd8, "R2 code 3 divides by 8");
    wr(3'd0, 16'h0005);
    measure(128, 16'd4, "R2 code 5 divides by 32");
    wr(3'd0, 16'h0000);
    measure(10, 16'd10, "R2 code 0 every clock");

    // R3 / R4 rollover with priority 2
    wr(3'd0, 16'h2000);
    check(irq_req === 1'b0, "R4 no irq without flag", 16'(irq_req), 16'h0);
    wr(3'd2, 16'hFFF0);
    repeat (20) @(negedge clk);
    check(irq_req === 1'b1, "R4 irq with flag and level", 16'(irq_req), 16'h1);
    rd(3'd0, 16'hA000, "R3 rollover sets flag");

    // R7 rollover between read and write cancels the clear
    wr(3'd2, 16'hFFF0);
    repeat (20) @(negedge clk);
    wr(3'd0, 16'h2000);
    rd(3'd0, 16'hA000, "R7 clear cancelled by rollover");

    // R5 proper exchange
    wr(3'd0, 16'h2000);
    rd(3'd0, 16'h2000, "R5 flag cleared");
    check(irq_req === 1'b0, "R5 irq drops with flag", 16'(irq_req), 16'h0);

    // R6 unarmed write of zero
    wr(3'd2, 16'hFFF0);
    repeat (20) @(negedge clk);
    wr(3'd0, 16'h2000);
    rd(3'd0, 16'hA000, "R6 unarmed clear ignored");
    wr(3'd0, 16'h8000);
    check(irq_req === 1'b0, "R4 level zero masks irq", 16'(irq_req), 16'h0);
    rd(3'd0, 16'h8000, "R4 flag kept with level zero");
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h0000, "R5 clear after second arm");

    // R8 software cannot set the flag
    wr(3'd0, 16'hB000);
    rd(3'd0, 16'h3000, "R8 write one does not set flag");
    check(irq_req === 1'b0, "R8 irq stays low", 16'(irq_req), 16'h0);

    // R9 reserved and odd addresses
    wr(3'd4, 16'hFFFF);
    wr(3'd6, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    rd(3'd4, 16'h0000, "R9 offset 4 reads zero");
    rd(3'd6, 16'h0000, "R9 offset 6 reads zero");
    rd(3'd1, 16'h0000, "R9 odd address reads zero");
    rd(3'd0, 16'h3000, "R9 control untouched by reserved writes");
    wr(3'd2, 16'h0100);
    wr(3'd3, 16'hFFFF);
    rd(3'd2, 16'h0101, "R9 odd write does not load count");
    wr(3'd0, 16'h7FFF);
    rd(3'd0, 16'h7E07, "R9 unused bits read zero");
    wr(3'd0, 16'h0000);

    // R12 input level
    pin_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd0, 16'h0100, "R12 input level in bit 8");
    pin_in = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule